// File: doc/BRIEF.md
# Continuous-Phase Binary FSK Tone Generator

This block turns a serial bit stream into a two-tone frequency-shift-keyed carrier by direct digital synthesis. Two tuning words are held, one for a data bit of 0 (the space tone) and one for a data bit of 1 (the mark tone). On each clock the registered data bit picks the active tuning word, and that word is added to a wrapping phase accumulator.

The upper accumulator bits index a sine table that is computed when the design is elaborated. The table is read twice per clock. The in-phase read uses the phase address as it is. The quadrature read uses the phase address advanced by a quarter turn. The two reads give signed samples that are 90 degrees apart.

A change of tone only swaps the increment. The accumulator is never reloaded, so the output phase has no jump at a bit boundary. A tuning word can be rewritten while the block runs, and the rewrite does not disturb the phase.

Top module: `cpfsk_dds`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears the accumulator, both tuning words, the tone select, both samples and `sample_vld` to zero after that edge.
- R2: At a rising edge with `tw_load` high, `tw_word` is stored into the space word (tuning word 0) when `tw_sel` is 0, or into the mark word (tuning word 1) when `tw_sel` is 1. The stored word drives the accumulator from the next edge onward. Without `tw_load`, both words keep their values.
- R3: The tone select register takes `data_bit` at every rising edge. At the following edge, a select of 0 adds the space word to the accumulator and a select of 1 adds the mark word.
- R4: At every rising edge out of reset, the 24-bit accumulator adds the active word modulo 2^24, with no saturation. A word of 0xFFFFFF therefore walks the phase backwards by one LSB per clock.
- R5: A change of `data_bit` never resets or reloads the accumulator. The sample stream carries on from the phase already reached.
- R6: `i_sample` equals round(2047 * sin(2*pi*a/256)) in 12-bit two's complement, where a is accumulator bits [23:16].
- R7: `q_sample` is the table entry at address (a + 64) mod 256. It therefore leads `i_sample` by a quarter cycle.
- R8: A sample reaches the output two edges after the accumulator value it is taken from. `sample_vld` is low until the second rising edge after reset is released and then stays high.
- R9: The frequency step is f_clk / 2^24 per LSB of a tuning word. A word of 0x010000 advances the table address by exactly one entry per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tw_load | input | 1 | Strobe that writes `tw_word` into the selected tuning word |
| tw_sel | input | 1 | Target of the write: 0 for the space word, 1 for the mark word |
| tw_word | input | 24 | Tuning word value to be written |
| data_bit | input | 1 | Serial data bit that selects the tone |
| i_sample | output | 12 | In-phase sample, signed |
| q_sample | output | 12 | Quadrature sample, signed, a quarter cycle ahead of `i_sample` |
| sample_vld | output | 1 | High once the output pipeline holds samples of the running accumulator |

## Verification
Only the upper byte of the accumulator reaches the ports. An error in the low accumulator bits, for example a wrong carry or a reload when the tone changes, shows up at the ports only after the error has carried into bit 16. With the tuning words used here that takes at most a few clocks. A wrong increment choice or a missed tuning-word write changes the address stepping, and both sample outputs show the change two edges after the faulty accumulator update. A wrong quarter-turn offset breaks the fixed lead of `q_sample` over `i_sample` at the first sample after reset.

// File: rtl/cpfsk_pkg.sv
package cpfsk_pkg;

  // Wrapping accumulator step; the carry out is dropped (modulo 2^width).
  function automatic logic [23:0] acc_add(input logic [23:0] acc, input logic [23:0] step);
    return acc + step;
  endfunction

  // Table address advanced by a quarter turn, wrapped to the table depth.
  function automatic int quarter_addr(input int addr, input int addr_w);
    return (addr + (1 << (addr_w - 2))) % (1 << addr_w);
  endfunction

  // Rounded sine amplitude of table entry k, peak value 2^(amp_w-1)-1.
  function automatic int sine_entry(input int k, input int addr_w, input int amp_w);
    real ang;
    real peak;
    ang  = 2.0 * 3.141592653589793 * k / (2.0 ** addr_w);
    peak = (2.0 ** (amp_w - 1)) - 1.0;
    return $rtoi($floor(peak * $sin(ang) + 0.5));
  endfunction

endpackage

// File: rtl/cpfsk_phase_acc.sv
module cpfsk_phase_acc #(
  parameter int ACC_W     = 24,
  parameter int NUM_TONES = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                tw_load,
  input  logic                                tw_sel,
  input  logic [ACC_W-1:0]                    tw_word,
  input  logic                                data_bit,
  output logic [ACC_W-1:0]                    acc_q,
  output logic [ACC_W-1:0]                    acc_step,
  output logic                                tone_q,
  output logic [NUM_TONES-1:0][ACC_W-1:0]     words_q
);
  import cpfsk_pkg::*;

  // One register per tone, written only when its index is selected.
  for (genvar t = 0; t < NUM_TONES; t++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words_q[t] <= '0;
      end else if (tw_load && (int'(tw_sel) == t)) begin
        words_q[t] <= tw_word;
      end
    end
  end

  assign acc_step = words_q[tone_q];

  // Tone change swaps only the step; the accumulator is never reloaded.
  always_ff @(posedge clk) begin
    if (rst) begin
      tone_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      tone_q <= data_bit;
      acc_q  <= acc_add(acc_q, acc_step);
    end
  end

endmodule

// File: rtl/cpfsk_sine_rom.sv
module cpfsk_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [ADDR_W-1:0]        addr_q,
  output logic signed [AMP_W-1:0]  lut_i,
  output logic signed [AMP_W-1:0]  lut_q
);
  import cpfsk_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic signed [AMP_W-1:0] tab [DEPTH];

  // Entries are computed at elaboration, one constant per address.
  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam int VAL = sine_entry(k, ADDR_W, AMP_W);
    assign tab[k] = AMP_W'(VAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_i <= '0;
      lut_q <= '0;
    end else begin
      lut_i <= tab[addr_i];
      lut_q <= tab[addr_q];
    end
  end

endmodule

// File: rtl/cpfsk_dds.sv
module cpfsk_dds #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tw_load,
  input  logic                     tw_sel,
  input  logic [ACC_W-1:0]         tw_word,
  input  logic                     data_bit,
  output logic signed [AMP_W-1:0]  i_sample,
  output logic signed [AMP_W-1:0]  q_sample,
  output logic                     sample_vld
);
  import cpfsk_pkg::*;

  localparam int NUM_TONES = 2;
  localparam int PIPE      = 2;

  // Named internal events, brought out for the bound checker.
  logic [ACC_W-1:0]                acc_q;
  logic [ACC_W-1:0]                acc_step;
  logic                            tone_q;
  logic [NUM_TONES-1:0][ACC_W-1:0] words_q;
  logic [ACC_W-1:0]                word0_q;
  logic [ACC_W-1:0]                word1_q;
  logic [ADDR_W-1:0]               addr_i;
  logic [ADDR_W-1:0]               addr_q;
  logic signed [AMP_W-1:0]         lut_i;
  logic signed [AMP_W-1:0]         lut_q;
  logic [PIPE-1:0]                 vld_pipe;

  assign word0_q = words_q[0];
  assign word1_q = words_q[1];

  cpfsk_phase_acc #(.ACC_W(ACC_W), .NUM_TONES(NUM_TONES)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .tw_load  (tw_load),
    .tw_sel   (tw_sel),
    .tw_word  (tw_word),
    .data_bit (data_bit),
    .acc_q    (acc_q),
    .acc_step (acc_step),
    .tone_q   (tone_q),
    .words_q  (words_q)
  );

  assign addr_i = acc_q[ACC_W-1 -: ADDR_W];
  assign addr_q = ADDR_W'(quarter_addr(int'(addr_i), ADDR_W));

  cpfsk_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .addr_i (addr_i),
    .addr_q (addr_q),
    .lut_i  (lut_i),
    .lut_q  (lut_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      i_sample <= '0;
      q_sample <= '0;
      vld_pipe <= '0;
    end else begin
      i_sample <= lut_i;
      q_sample <= lut_q;
      vld_pipe <= {vld_pipe[PIPE-2:0], 1'b1};
    end
  end

  assign sample_vld = vld_pipe[PIPE-1];

endmodule

// File: rtl/cpfsk_dds_chk.sv
module cpfsk_dds_chk #(
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             data_bit,
  input logic             tw_load,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] acc_step,
  input logic             tone_q,
  input logic [ACC_W-1:0] word0_q,
  input logic [ACC_W-1:0] word1_q,
  input logic             sample_vld
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (acc_q == '0) && !tone_q && !sample_vld && (word0_q == '0) && (word1_q == '0)); // R1

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst) !tw_load |=> $stable(word0_q) && $stable(word1_q)); // R2

  AST_TONE_FOLLOW: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> tone_q == $past(data_bit)); // R3

  AST_ACC_WRAP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> acc_q == ACC_W'($past(acc_q) + $past(acc_step))); // R4

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst) (tone_q != data_bit) |=> acc_q == ACC_W'($past(acc_q) + $past(acc_step))); // R5

  AST_VLD_HOLD: assert property (@(posedge clk) disable iff (rst) sample_vld |=> sample_vld); // R8

endmodule

bind cpfsk_dds cpfsk_dds_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .data_bit   (data_bit),
  .tw_load    (tw_load),
  .acc_q      (acc_q),
  .acc_step   (acc_step),
  .tone_q     (tone_q),
  .word0_q    (word0_q),
  .word1_q    (word1_q),
  .sample_vld (sample_vld)
);

// File: tb/test_cpfsk_dds.sv
`timescale 1ns/1ps
module test_cpfsk_dds;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tw_load = 1'b0;
  logic        tw_sel = 1'b0;
  logic [23:0] tw_word = '0;
  logic        data_bit = 1'b0;
  logic signed [11:0] i_sample;
  logic signed [11:0] q_sample;
  logic        sample_vld;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string tag   = "R1";

  always #2 clk = ~clk;  // 250 MHz

  cpfsk_dds i_cpfsk_dds (
    .clk(clk), .rst(rst), .tw_load(tw_load), .tw_sel(tw_sel), .tw_word(tw_word),
    .data_bit(data_bit), .i_sample(i_sample), .q_sample(q_sample), .sample_vld(sample_vld)
  );

  // Reference values from the requirements.
  function automatic int ref_sin(input int idx);
    real x;
    x = 2047.0 * $sin(6.283185307179586 * real'(idx % 256) / 256.0);
    return (x >= 0.0) ? int'($floor(x + 0.5)) : -int'($floor(-x + 0.5));
  endfunction

  // Behavioural model state.
  longint m_phase = 0;
  longint m_word[2] = '{0, 0};
  int     m_sel = 0;
  int     m_mid_i = 0, m_mid_q = 0;
  int     m_out_i = 0, m_out_q = 0;
  int     m_edges = 0;

  always @(posedge clk) begin
    int a;
    cycles++;
    if (rst) begin
      m_phase = 0; m_word[0] = 0; m_word[1] = 0; m_sel = 0;
      m_mid_i = 0; m_mid_q = 0; m_out_i = 0; m_out_q = 0; m_edges = 0;
    end else begin
      m_out_i = m_mid_i;
      m_out_q = m_mid_q;
      a = int'(m_phase / 65536);
      m_mid_i = ref_sin(a);
      m_mid_q = ref_sin(a + 64);
      m_phase = (m_phase + m_word[m_sel]) % 64'd16777216;
      m_sel = int'(data_bit);
      if (tw_load) m_word[int'(tw_sel)] = longint'(tw_word);
      if (m_edges < 2) m_edges++;
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", t, what, act, exp, cycles);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      check(tag, "i_sample", int'(i_sample), m_out_i);
      check(tag, "q_sample", int'(q_sample), m_out_q);
      check("R8", "sample_vld", int'(sample_vld), (m_edges >= 2) ? 1 : 0);
    end
  end

  task automatic load(input bit sel, input logic [23:0] w);
    @(negedge clk);
    tw_sel = sel; tw_word = w; tw_load = 1'b1;
    @(negedge clk);
    tw_load = 1'b0;
  endtask

  task automatic run(input int n, input int pattern);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (pattern)
        0: data_bit = 1'b0;
        1: data_bit = 1'b1;
        2: data_bit = k[0];
        3: data_bit = k[2];
        default: data_bit = 1'($urandom);
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1", "i_sample in reset", int'(i_sample), 0);
    check("R1", "q_sample in reset", int'(q_sample), 0);
    check("R1", "sample_vld in reset", int'(sample_vld), 0);
    rst = 1'b0;
    // R7: first sample from phase 0 gives I=0, Q=peak after two edges
    @(negedge clk);
    check("R8", "vld after one edge", int'(sample_vld), 0);
    @(negedge clk);
    check("R7", "q at phase zero", int'(q_sample), 2047);
    check("R6", "i at phase zero", int'(i_sample), 0);

    tag = "R9";
    load(1'b0, 24'h010000);
    run(300, 0);
    tag = "R2";
    load(1'b1, 24'h030000);
    run(50, 1);
    tag = "R3";
    run(200, 2);
    tag = "R5";
    load(1'b0, 24'h012345);
    load(1'b1, 24'h0789AB);
    run(400, 3);
    tag = "R4";
    load(1'b0, 24'hFFFFFF);
    load(1'b1, 24'hF00001);
    run(400, 4);
    tag = "R6";
    for (int r = 0; r < 6; r++) begin
      load(1'($urandom), 24'($urandom));
      run(150, 4);
    end
    tag = "R7";
    load(1'b0, 24'h004000);
    run(600, 0);

    // R1: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "i_sample after mid reset", int'(i_sample), 0);
    check("R1", "sample_vld after mid reset", int'(sample_vld), 0);
    rst = 1'b0;
    tag = "R2";
    load(1'b1, 24'h020000);
    run(100, 1);
    tag = "R5";
    run(200, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule